// File: doc/BRIEF.md
# Shiftable Sample Memory

This block is a small synchronous word store for a bus-based datapath. It keeps intermediate results and delayed samples. Besides ordinary write and read, it can copy the word at the addressed slot into the next slot up in a single cycle. Repeated copies of this kind build a delay line for filter taps in place. A clear strobe wipes every slot at once.

Four strobes select the operation: clear, write, shift and read. When several are raised together, a fixed priority decides which one runs, and only that one runs. Read data is registered. It is presented on the output bus for one cycle, together with a drive-enable flag that a shared bus can use to gate the data. The bus itself and the sequencer that issues the strobes lie outside this block.

Top module: `shift_ram`

## Requirements
- R1: While `rst_ni` is low, every slot is zero, `dout_en_o` is 0 and `dout_o` is 0.
- R2: The memory has eight slots, selected by a 3-bit address. A word written to a slot reads back unchanged, and each slot holds its own value.
- R3: A read sampled on a clock edge makes `dout_en_o` 1 and `dout_o` equal to the addressed word after that edge, for exactly one cycle. In every other cycle `dout_en_o` is 0 and `dout_o` is 0.
- R4: A shift at address k copies slot k into slot k+1. Slot k keeps its value, so the operation is a copy and not a move.
- R5: A shift at address 7 has no effect, and in particular slot 0 is not written.
- R6: A clear zeroes all eight slots in one cycle. It takes priority over write, shift and read, so a read raised together with a clear produces no output.
- R7: When write is raised together with shift and/or read, only the write takes effect. No shift happens and no read output appears.
- R8: When shift and read are raised together without write, only the shift takes effect and no read output appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear-all strobe (highest priority) |
| wr_i | input | 1 | Write strobe |
| sh_i | input | 1 | Shift strobe: copy slot addr into slot addr+1 |
| rd_i | input | 1 | Read strobe (lowest priority) |
| addr_i | input | 3 | Slot address |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Registered read data, zero when not enabled |
| dout_en_o | output | 1 | High for the one cycle that read data is valid |

## Verification
The bench shifts into the top slot and then reads slot 0. A design that wraps the address would corrupt slot 0 there. After a shift, the bench reads back the source slot, which catches a design that moves the word instead of copying it. It raises colliding strobes and then inspects the slots that the losing operation would have touched, so a broken priority order shows up as an unexpected output pulse or a stray copy. It also builds a full delay line and resets in the middle of a run, which exposes missing slot logic at the ends of the array and a clear or reset that leaves stale data behind.

// File: rtl/shift_ram_pkg.sv
package shift_ram_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CLR,
    OP_WR,
    OP_SH,
    OP_RD
  } ram_op_e;
endpackage

// File: rtl/shift_ram_decode.sv
module shift_ram_decode
  import shift_ram_pkg::*;
(
  input  logic    clr_i,
  input  logic    wr_i,
  input  logic    sh_i,
  input  logic    rd_i,
  output ram_op_e op_o
);
  // fixed priority: clear > write > shift > read
  always_comb begin
    if (clr_i)     op_o = OP_CLR;
    else if (wr_i) op_o = OP_WR;
    else if (sh_i) op_o = OP_SH;
    else if (rd_i) op_o = OP_RD;
    else           op_o = OP_IDLE;
  end
endmodule

// File: rtl/shift_ram_array.sv
module shift_ram_array
  import shift_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  ram_op_e                       op_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             din_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  words_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] word_q;
    logic              wr_hit;
    logic              sh_hit;
    logic [DATA_W-1:0] sh_src;

    assign wr_hit = (op_i == OP_WR) && (addr_i == ADDR_W'(i));

    // slot 0 has no lower neighbour; a shift at the top address has no target
    if (i == 0) begin : g_head
      assign sh_hit = 1'b0;
      assign sh_src = '0;
    end else begin : g_tail
      assign sh_hit = (op_i == OP_SH) && (addr_i == ADDR_W'(i - 1));
      assign sh_src = words_o[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              word_q <= '0;
      else if (op_i == OP_CLR)  word_q <= '0;
      else if (wr_hit)          word_q <= din_i;
      else if (sh_hit)          word_q <= sh_src;
    end

    assign words_o[i] = word_q;
  end
endmodule

// File: rtl/shift_ram_rdport.sv
module shift_ram_rdport
  import shift_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  ram_op_e                       op_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]  words_i,
  output logic [DATA_W-1:0]             dout_o,
  output logic                          dout_en_o
);
  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= (op_i == OP_RD);
      if (op_i == OP_RD) data_q <= words_i[addr_i];
    end
  end

  // bus side sees zero unless the word is valid
  assign dout_o    = vld_q ? data_q : '0;
  assign dout_en_o = vld_q;
endmodule

// File: rtl/shift_ram.sv
module shift_ram
  import shift_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              sh_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  ram_op_e                      op;
  logic [DEPTH-1:0][DATA_W-1:0] words;

  shift_ram_decode i_decode (
    .clr_i (clr_i),
    .wr_i  (wr_i),
    .sh_i  (sh_i),
    .rd_i  (rd_i),
    .op_o  (op)
  );

  shift_ram_array #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .addr_i  (addr_i),
    .din_i   (din_i),
    .words_o (words)
  );

  shift_ram_rdport #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) i_rdport (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .addr_i    (addr_i),
    .words_i   (words),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o)
  );
endmodule

// File: rtl/shift_ram_chk.sv
module shift_ram_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              wr_i,
  input logic              sh_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_en_o
);
  logic rd_only;
  assign rd_only = rd_i && !clr_i && !wr_i && !sh_i;

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!dout_en_o && dout_o == '0));

  assert_write_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) ##1 (rd_only && addr_i == $past(addr_i)) |=> dout_o == $past(din_i, 2));

  assert_read_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_only |=> dout_en_o);

  assert_en_needs_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !dout_en_o);

  assert_clear_blocks_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !dout_en_o);

  assert_clear_zeroes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i ##1 rd_only |=> dout_o == '0);

  assert_write_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !dout_en_o);

  assert_shift_beats_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_i |=> !dout_en_o);
endmodule

bind shift_ram shift_ram_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) i_chk (.*);

// File: tb/test_shift_ram.sv
module test_shift_ram;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       clr_i, wr_i, sh_i, rd_i;
  logic [2:0] addr_i;
  logic [7:0] din_i;
  logic [7:0] dout_o;
  logic       dout_en_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  shift_ram i_shift_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .wr_i      (wr_i),
    .sh_i      (sh_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .din_i     (din_i),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o)
  );

  // {req[3:0], clr, wr, rd, sh, addr[2:0], din[7:0], exp_en, exp_dout[7:0]}
  // expected values are the outputs after the edge that samples the vector
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd2, 4'b0100, 3'd1, 8'h3D, 1'b0, 8'h00}, // R2 write slot 1
    {4'd2, 4'b0010, 3'd1, 8'h00, 1'b1, 8'h3D}, // R2 read slot 1
    {4'd4, 4'b0001, 3'd1, 8'h00, 1'b0, 8'h00}, // R4 shift 1 -> 2
    {4'd4, 4'b0010, 3'd2, 8'h00, 1'b1, 8'h3D}, // R4 slot 2 got the copy
    {4'd4, 4'b0010, 3'd1, 8'h00, 1'b1, 8'h3D}, // R4 source kept
    {4'd2, 4'b0100, 3'd7, 8'hA5, 1'b0, 8'h00}, // R2 write slot 7
    {4'd5, 4'b0001, 3'd7, 8'h00, 1'b0, 8'h00}, // R5 shift at top
    {4'd5, 4'b0010, 3'd7, 8'h00, 1'b1, 8'hA5}, // R5 top intact
    {4'd5, 4'b0010, 3'd0, 8'h00, 1'b1, 8'h00}, // R5 no wrap into slot 0
    {4'd7, 4'b0111, 3'd3, 8'h11, 1'b0, 8'h00}, // R7 write+read+shift
    {4'd7, 4'b0010, 3'd3, 8'h00, 1'b1, 8'h11}, // R7 write landed
    {4'd7, 4'b0010, 3'd4, 8'h00, 1'b1, 8'h00}, // R7 no shift happened
    {4'd8, 4'b0011, 3'd3, 8'h00, 1'b0, 8'h00}, // R8 shift+read
    {4'd8, 4'b0010, 3'd4, 8'h00, 1'b1, 8'h11}, // R8 shift landed
    {4'd3, 4'b0000, 3'd4, 8'h00, 1'b0, 8'h00}, // R3 idle drives zero
    {4'd6, 4'b1111, 3'd5, 8'hFF, 1'b0, 8'h00}, // R6 clear wins all
    {4'd6, 4'b0010, 3'd5, 8'h00, 1'b1, 8'h00}, // R6 write suppressed
    {4'd6, 4'b0010, 3'd7, 8'h00, 1'b1, 8'h00}, // R6 slot 7 cleared
    {4'd6, 4'b0010, 3'd2, 8'h00, 1'b1, 8'h00}  // R6 slot 2 cleared
  };

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(input string req, input logic en, input logic [7:0] d);
    total++;
    if (dout_en_o !== en || dout_o !== d) begin
      bad++;
      $display("FAIL %s: en=%0b dout=%02h expected en=%0b dout=%02h",
               req, dout_en_o, dout_o, en, d);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic r, input logic s,
                       input logic [2:0] a, input logic [7:0] d);
    clr_i = c; wr_i = w; rd_i = r; sh_i = s; addr_i = a; din_i = d;
    @(negedge clk_i);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
      summary();
    end
  end

  initial begin
    rst_ni = 1'b0;
    clr_i = 1'b0; wr_i = 1'b0; sh_i = 1'b0; rd_i = 1'b0;
    addr_i = '0; din_i = '0;
    #1;
    check("R1", 1'b0, 8'h00);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: all slots empty after reset
    for (int a = 0; a < 8; a++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b0, 3'(a), 8'h00);
      check("R1", 1'b1, 8'h00);
    end

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VEC[i];
      drive(v[27-4], v[26-4], v[25-4], v[24-4], v[19:17], v[16:9]);
      check($sformatf("R%0d vec%0d", v[27:24], i), v[8], v[7:0]);
    end

    // R2: distinct word in every slot
    for (int a = 0; a < 8; a++) drive(1'b0, 1'b1, 1'b0, 1'b0, 3'(a), 8'(a * 8'h13 + 8'h07));
    for (int a = 0; a < 8; a++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b0, 3'(a), 8'h00);
      check("R2", 1'b1, 8'(a * 8'h13 + 8'h07));
    end

    // R4: delay line fill from slot 0 upward
    drive(1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'h5A);
    for (int a = 0; a < 7; a++) drive(1'b0, 1'b0, 1'b0, 1'b1, 3'(a), 8'h00);
    for (int a = 0; a < 8; a++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b0, 3'(a), 8'h00);
      check("R4", 1'b1, 8'h5A);
    end

    // R3: single-cycle pulse then zero
    idle();
    check("R3", 1'b0, 8'h00);

    // R1: asynchronous reset mid-run
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 8'h00);
    rst_ni = 1'b0;
    #1;
    check("R1", 1'b0, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 3'd6, 8'h00);
    check("R1", 1'b1, 8'h00);

    idle();
    summary();
  end
endmodule